// File: doc/BRIEF.md
# ADC Control and Power Sequencer

This block holds the 32-bit control word of an analog-to-digital converter and runs the logic that acts on it. From the system clock it derives a converter clock, given as a one-cycle enable pulse whose spacing is set by a programmable divide value. A power sequencer either keeps the analog section on all the time, or, in low-power mode, switches it on only when a conversion is requested. In low-power mode it waits out a start-up delay that depends on the resolution, samples, and switches off again once no further request is waiting.

Software starts a self-calibration by setting one bit of the control word. The converter is told with a one-cycle start pulse. While calibration runs, the control word ignores all writes, and it clears the calibration bit itself when the converter reports completion. The converter itself is not part of this block: it appears only as handshake signals. Triggers are sampled every system clock, and each cycle in which `hw_trig` or `sw_trig` is high counts as one request.

Top module: `adc_ctrl_seq`

## Requirements
- R1: Out of reset the control word reads 0x00000000, and `sample_start` and `cal_start` are low.
- R2: With `async_mode` low, `conv_tick` is high for one system clock in every (D+1) clocks, where D is control bits 7:0.
- R3: With `async_mode` high, the divide value has no effect and `conv_tick` is high on every clock.
- R4: With control bit 10 at 0, `pwr_up` equals `adc_en`. A request in an idle cycle raises `sample_start` for one cycle in the next clock.
- R5: With control bit 10 at 1, `pwr_up` is low while idle and rises in the clock after a request. `sample_start` then follows after exactly 15 `conv_tick` pulses when `res10` is 0.
- R6: In low-power mode with `res10` at 1, the start-up delay is 30 `conv_tick` pulses.
- R7: In low-power mode, a `conv_done` with no waiting request returns the sequencer to idle, and `pwr_up` is low in the next clock.
- R8: A request that arrives during a conversion is held. At `conv_done`, `sample_start` pulses in the next clock without a new start-up delay, and `pwr_up` stays high.
- R9: While `adc_en` is low, `pwr_up` and `sample_start` stay low and requests have no effect.
- R10: A write with bit 30 set takes its other fields in the same write, reads bit 30 as 1, and pulses `cal_start` for one clock.
- R11: While bit 30 reads 1, writes leave the control word unchanged. `cal_done` clears bit 30 in the next clock, after which writes are taken again.
- R12: Only bits 7:0, 10 and 30 are stored. All other bits read back as 0 whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| async_mode | input | 1 | Converter runs from its own clock; divide field ignored |
| adc_en | input | 1 | Converter enable |
| res10 | input | 1 | 10-bit resolution selected (long start-up) |
| hw_trig | input | 1 | Hardware conversion request |
| sw_trig | input | 1 | Software conversion request |
| conv_tick | output | 1 | Converter clock enable pulse |
| pwr_up | output | 1 | Analog section power request |
| sample_start | output | 1 | One-cycle start-of-sample pulse |
| conv_done | input | 1 | Converter reports end of conversion |
| cal_start | output | 1 | One-cycle calibration start pulse |
| cal_done | input | 1 | Converter reports end of calibration |

## Verification
The divider is tried with divide values 0, 3 and 7, and then in asynchronous mode with a nonzero value. This separates the D+1 spacing from an off-by-one error and from a divide field that leaks into asynchronous mode. The sequencer gets single requests in full-power mode, in low-power mode at both resolutions, a request during a busy conversion, and requests with the enable low. Counting tick pulses from request to sample tells the 15-tick delay from the 30-tick one and catches an extra or missing tick. Calibration is exercised with a combined write, a write while locked, completion, and a write after completion, so that a stuck lock is told apart from a missing one.

// File: rtl/adc_ctrl_pkg.sv
// Package adc_ctrl_pkg
// Shared field positions, widths and the sequencer state type for the
// ADC control and power sequencer. Assumes a 32-bit control word.
package adc_ctrl_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned DIV_W    = 8;
    localparam int unsigned LP_BIT   = 10;
    localparam int unsigned CAL_BIT  = 30;
    localparam logic [WORD_W-1:0] STORED_MASK =
        (WORD_W'(1) << CAL_BIT) | (WORD_W'(1) << LP_BIT) | WORD_W'((1 << DIV_W) - 1);

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WARM = 2'd1,
        SEQ_BUSY = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_clk_div.sv
// Module adc_clk_div
// Produces the converter clock as a one-cycle enable every (div+1) system
// clocks. In asynchronous mode the enable is held high and div is unused.
// Assumes div may change at any time; the counter wraps on reaching it.
module adc_clk_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             async_mode,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    // Terminal count reached (>= so a lowered div takes effect at once)
    assign wrap = (cnt_q >= div);

    // Count system clocks between enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (async_mode || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Enable output
    assign tick = async_mode | wrap;
endmodule

// File: rtl/adc_ctrl_reg.sv
// Module adc_ctrl_reg
// Stores the divide field, the low-power select and the calibration bit.
// A write that sets the calibration bit also takes the other fields and
// raises a one-cycle start pulse; while the bit is set, writes are dropped
// and the completion input clears it. Unstored bits read as zero.
module adc_ctrl_reg
    import adc_ctrl_pkg::*;
#(
    parameter int unsigned DIV_W = adc_ctrl_pkg::DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              cal_done,
    output logic [DIV_W-1:0]  div,
    output logic              lowpwr,
    output logic              cal_start,
    output logic [WORD_W-1:0] rdata
);
    logic [DIV_W-1:0] div_q;
    logic             lp_q;
    logic             cal_q;
    logic             cal_start_q;

    // Register update with calibration write-lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q       <= '0;
            lp_q        <= 1'b0;
            cal_q       <= 1'b0;
            cal_start_q <= 1'b0;
        end else begin
            cal_start_q <= 1'b0;
            if (cal_q) begin
                if (cal_done) begin
                    cal_q <= 1'b0;
                end
            end else if (reg_wr) begin
                div_q <= reg_wdata[DIV_W-1:0];
                lp_q  <= reg_wdata[LP_BIT];
                if (reg_wdata[CAL_BIT]) begin
                    cal_q       <= 1'b1;
                    cal_start_q <= 1'b1;
                end
            end
        end
    end

    // Read-back assembly; unstored positions are zero
    always_comb begin
        rdata                 = '0;
        rdata[DIV_W-1:0]      = div_q;
        rdata[LP_BIT]         = lp_q;
        rdata[CAL_BIT]        = cal_q;
    end

    assign div       = div_q;
    assign lowpwr    = lp_q;
    assign cal_start = cal_start_q;
endmodule

// File: rtl/adc_pwr_seq.sv
// Module adc_pwr_seq
// Power and sample sequencer. In full-power mode the analog section follows
// the enable and a request starts a sample in the next clock. In low-power
// mode a request powers up, waits WARM_SHORT or WARM_LONG converter ticks,
// then samples; after the conversion it powers down unless a request is
// held. Assumes conv_done is only given while a conversion is running.
module adc_pwr_seq
    import adc_ctrl_pkg::*;
#(
    parameter int unsigned WARM_SHORT = 15,
    parameter int unsigned WARM_LONG  = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adc_en,
    input  logic lowpwr,
    input  logic res10,
    input  logic tick,
    input  logic trig,
    input  logic conv_done,
    output logic pwr_up,
    output logic sample_start
);
    localparam int unsigned WMAX  = (WARM_LONG > WARM_SHORT) ? WARM_LONG : WARM_SHORT;
    localparam int unsigned CNT_W = $clog2(WMAX + 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] wcnt_q;
    logic [CNT_W-1:0] last_tick;
    logic             pend_q;
    logic             start_q;

    // Index of the final warm-up tick for the selected resolution
    assign last_tick = res10 ? CNT_W'(WARM_LONG - 1) : CNT_W'(WARM_SHORT - 1);

    // Sequencer state, warm-up count and held request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            wcnt_q  <= '0;
            pend_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (!adc_en) begin
                state_q <= SEQ_IDLE;
                wcnt_q  <= '0;
                pend_q  <= 1'b0;
            end else begin
                case (state_q)
                    SEQ_IDLE: begin
                        if (trig) begin
                            if (lowpwr) begin
                                state_q <= SEQ_WARM;
                                wcnt_q  <= '0;
                            end else begin
                                state_q <= SEQ_BUSY;
                                start_q <= 1'b1;
                            end
                        end
                    end
                    SEQ_WARM: begin
                        if (tick) begin
                            if (wcnt_q >= last_tick) begin
                                state_q <= SEQ_BUSY;
                                start_q <= 1'b1;
                                wcnt_q  <= '0;
                            end else begin
                                wcnt_q <= wcnt_q + 1'b1;
                            end
                        end
                    end
                    SEQ_BUSY: begin
                        if (conv_done) begin
                            if (pend_q || trig) begin
                                start_q <= 1'b1;
                                pend_q  <= 1'b0;
                            end else begin
                                state_q <= SEQ_IDLE;
                            end
                        end else if (trig) begin
                            pend_q <= 1'b1;
                        end
                    end
                    default: state_q <= SEQ_IDLE;
                endcase
            end
        end
    end

    // Power request: enable-gated, held on outside idle in low-power mode
    assign pwr_up       = adc_en & (~lowpwr | (state_q != SEQ_IDLE));
    assign sample_start = start_q;
endmodule

// File: rtl/adc_ctrl_seq.sv
// Module adc_ctrl_seq (top)
// Control word, converter clock enable and power/sample sequencer for an
// ADC. Triggers are level-sampled: each high cycle is one request.
module adc_ctrl_seq
    import adc_ctrl_pkg::*;
#(
    parameter int unsigned WARM_SHORT = 15,
    parameter int unsigned WARM_LONG  = 30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        async_mode,
    input  logic        adc_en,
    input  logic        res10,
    input  logic        hw_trig,
    input  logic        sw_trig,
    output logic        conv_tick,
    output logic        pwr_up,
    output logic        sample_start,
    input  logic        conv_done,
    output logic        cal_start,
    input  logic        cal_done
);
    logic [DIV_W-1:0] div;
    logic             lowpwr;
    logic             trig;

    // Merge the two request sources
    assign trig = hw_trig | sw_trig;

    adc_ctrl_reg #(.DIV_W(DIV_W)) reg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .cal_done  (cal_done),
        .div       (div),
        .lowpwr    (lowpwr),
        .cal_start (cal_start),
        .rdata     (reg_rdata)
    );

    adc_clk_div #(.DIV_W(DIV_W)) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_mode (async_mode),
        .div        (div),
        .tick       (conv_tick)
    );

    adc_pwr_seq #(.WARM_SHORT(WARM_SHORT), .WARM_LONG(WARM_LONG)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .adc_en       (adc_en),
        .lowpwr       (lowpwr),
        .res10        (res10),
        .tick         (conv_tick),
        .trig         (trig),
        .conv_done    (conv_done),
        .pwr_up       (pwr_up),
        .sample_start (sample_start)
    );
endmodule

// File: rtl/adc_ctrl_seq_chk.sv
// Module adc_ctrl_seq_chk
// Port-level properties of adc_ctrl_seq, attached by bind below.
module adc_ctrl_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [31:0] reg_rdata,
    input logic        async_mode,
    input logic        adc_en,
    input logic        conv_tick,
    input logic        pwr_up,
    input logic        sample_start,
    input logic        cal_start
);
    localparam logic [31:0] KEEP = 32'h4000_04FF;

    // R9
    en_gates_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_en |-> !pwr_up);

    // R4
    full_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_en && !reg_rdata[10]) |-> pwr_up);

    // R5
    sample_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_start |-> pwr_up);

    // R12
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~KEEP) == 32'h0);

    // R11
    cal_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[30] && reg_wr) |=> $stable(reg_rdata[29:0]));

    // R10
    cal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> reg_rdata[30]);

    // R3
    async_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        async_mode |-> conv_tick);
endmodule

bind adc_ctrl_seq adc_ctrl_seq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rdata    (reg_rdata),
    .async_mode   (async_mode),
    .adc_en       (adc_en),
    .conv_tick    (conv_tick),
    .pwr_up       (pwr_up),
    .sample_start (sample_start),
    .cal_start    (cal_start)
);

// File: tb/adc_ctrl_seq_tb_top.sv
// Directed bench for adc_ctrl_seq: one task per scenario.
// Inputs change and outputs are read on the falling clock edge.
module adc_ctrl_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        async_mode, adc_en, res10, hw_trig, sw_trig;
    logic        conv_tick, pwr_up, sample_start, conv_done, cal_start, cal_done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc_ctrl_seq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .async_mode(async_mode), .adc_en(adc_en),
        .res10(res10), .hw_trig(hw_trig), .sw_trig(sw_trig),
        .conv_tick(conv_tick), .pwr_up(pwr_up), .sample_start(sample_start),
        .conv_done(conv_done), .cal_start(cal_start), .cal_done(cal_done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse_trig();
        hw_trig = 1'b1;
        step();
        hw_trig = 1'b0;
    endtask

    task automatic pulse_done();
        conv_done = 1'b1;
        step();
        conv_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; reg_wr = 0; reg_wdata = '0; async_mode = 0; adc_en = 0;
        res10 = 0; hw_trig = 0; sw_trig = 0; conv_done = 0; cal_done = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check(reg_rdata == 32'h0, "R1 rdata", reg_rdata, 0);
        check(!sample_start && !cal_start, "R1 pulses", {sample_start, cal_start}, 0);
    endtask

    task automatic t_div(input int d);
        int gap = 0;
        wr(32'(d));
        async_mode = 0;
        while (!conv_tick) step();
        step(); gap = 1;
        while (!conv_tick && gap < 600) begin step(); gap++; end
        // R2 tick spacing is d+1
        check(gap == d + 1, "R2 divide spacing", gap, d + 1);
    endtask

    task automatic t_async();
        int highs = 0;
        wr(32'h5);
        async_mode = 1;
        step();
        for (int i = 0; i < 8; i++) begin
            if (conv_tick) highs++;
            step();
        end
        // R3 divide ignored in asynchronous mode
        check(highs == 8, "R3 async tick", highs, 8);
        async_mode = 0;
    endtask

    task automatic t_normal();
        wr(32'h1);
        adc_en = 1;
        step();
        // R4 full power follows enable
        check(pwr_up == 1, "R4 idle power", pwr_up, 1);
        sw_trig = 1; step(); sw_trig = 0;
        check(sample_start == 1, "R4 sample next clock", sample_start, 1);
        step();
        check(sample_start == 0, "R4 single pulse", sample_start, 0);
        pulse_done();
        check(pwr_up == 1, "R4 power after done", pwr_up, 1);
    endtask

    task automatic t_lowpwr(input bit r10, input int expn, input string req);
        int ticks = 0;
        int guard = 0;
        res10 = r10;
        wr(32'h0000_0402);
        adc_en = 1;
        step();
        // R5 idle power off in low-power mode
        check(pwr_up == 0, "R5 idle off", pwr_up, 0);
        pulse_trig();
        check(pwr_up == 1, "R5 power on request", pwr_up, 1);
        while (!sample_start && guard < 2000) begin
            if (conv_tick) ticks++;
            step(); guard++;
        end
        // R5 / R6 start-up tick count
        check(ticks == expn, req, ticks, expn);
        step();
        pulse_done();
        // R7 power down when nothing waits
        check(pwr_up == 0, "R7 power off after done", pwr_up, 0);
        res10 = 0;
    endtask

    task automatic t_pending();
        int guard = 0;
        wr(32'h0000_0400);
        adc_en = 1;
        pulse_trig();
        while (!sample_start && guard < 2000) begin step(); guard++; end
        step();
        pulse_trig();
        pulse_done();
        // R8 held request restarts at once
        check(sample_start == 1, "R8 restart sample", sample_start, 1);
        check(pwr_up == 1, "R8 power held", pwr_up, 1);
        step();
        pulse_done();
        check(pwr_up == 0, "R8 off after last", pwr_up, 0);
    endtask

    task automatic t_disabled();
        bit seen = 0;
        adc_en = 0;
        wr(32'h0000_0400);
        pulse_trig();
        for (int i = 0; i < 40; i++) begin
            if (pwr_up || sample_start) seen = 1;
            step();
        end
        // R9 enable low blocks power and sampling
        check(!seen, "R9 low-power disabled", seen, 0);
        wr(32'h0);
        sw_trig = 1; step(); sw_trig = 0;
        check(!pwr_up && !sample_start, "R9 full-power disabled", {pwr_up, sample_start}, 0);
    endtask

    task automatic t_cal();
        wr(32'h4000_0483);
        // R10 combined write and start pulse
        check(reg_rdata == 32'h4000_0483, "R10 combined write", reg_rdata, 32'h4000_0483);
        check(cal_start == 1, "R10 start pulse", cal_start, 1);
        step();
        check(cal_start == 0, "R10 pulse width", cal_start, 0);
        wr(32'h0000_0005);
        // R11 write ignored while locked
        check(reg_rdata == 32'h4000_0483, "R11 locked", reg_rdata, 32'h4000_0483);
        cal_done = 1; step(); cal_done = 0;
        check(reg_rdata == 32'h0000_0483, "R11 cleared", reg_rdata, 32'h0000_0483);
        wr(32'h0000_0005);
        check(reg_rdata == 32'h0000_0005, "R11 unlocked", reg_rdata, 32'h5);
    endtask

    task automatic t_reserved();
        wr(32'hBFFF_FFFF);
        // R12 only stored bits read back
        check(reg_rdata == 32'h0000_04FF, "R12 reserved zero", reg_rdata, 32'h4FF);
        wr(32'h0);
    endtask

    initial begin
        t_reset();
        t_div(0);
        t_div(3);
        t_div(7);
        t_async();
        t_normal();
        t_lowpwr(1'b0, 15, "R5 short start-up");
        t_lowpwr(1'b1, 30, "R6 long start-up");
        t_pending();
        t_disabled();
        t_cal();
        t_reserved();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule